// File: doc/BRIEF.md
# Randomized Memory Traffic Master with Shadow Check

This block is a synthesizable bus master for stress-testing a 16-bit memory access port. It issues a stream of pseudo-random word and byte reads and writes into two 128-word windows: one fixed at byte address FE00 in program memory, the other at a parameterized base in data memory. Every request is held on the port until the far side signals ready. After that, the port returns to zero for at least one cycle.

The master keeps a shadow copy of both windows. At reset the shadow is loaded with a computed pattern, and the memory under test must be loaded with the same pattern before traffic starts. Every successful write is merged into the shadow. Every read is compared against the shadow under the byte mask of the access. A response flag that reports failure, or read data that does not match the shadow, increments a per-direction error counter. Completed reads and writes are counted separately.

A cancel input aborts the transfer in progress without counting or checking it. While reset is asserted, no traffic is issued and no read is checked.

Top module: `mem_stress_master`

## Requirements
- R1: The strobe encodes the access. 00 is a read, 11 is a 16-bit write, 01 is a write of the low byte (even address) and 10 is a write of the high byte (odd address). For a byte write, the byte sits on the matching data lane and the other lane is zero. For a read, the write data is zero.
- R2: While enable is high and ready is low (and cancel is low), enable, address, strobe and write data keep their values from cycle to cycle.
- R3: At a clock edge where enable and ready are both high, the transfer completes. In the following cycle, enable, address, strobe and write data are all zero.
- R4: At completion, the response flag is sampled: 0 means success and 1 means failure. A write whose flag is 1 increments the write-error counter by one and leaves the shadow unchanged.
- R5: A completed read increments the read-error counter by exactly one if either of these holds: the flag is 1, or the read data differs from the shadow word under the mask. The mask is FFFF for 16-bit reads, FF00 for odd byte reads and 00FF for even byte reads. Bits outside the mask are ignored.
- R6: After each release there is one idle cycle. One further idle cycle is added when bits [7:0] of the random word are below 85, unless gap_off is high at the decision edge.
- R7: Each access uses one random word and then advances it. The random word is a 32-bit shift register that starts at SEED and steps to {s[30:0], s[31]^s[21]^s[1]^s[0]}. Its fields are decoded as follows:
  - A read is chosen when bits [15:8] are below 85.
  - Bit 16 picks the window (1 = program window).
  - Bits [23:17] give the word offset.
  - Bit 24 = 1 selects a 16-bit access; otherwise bit 25 selects the byte lane.
  - The write data is s[31:16] ^ {s[7:0], s[15:8]}.
- R8: The byte address is the window base plus twice the offset, plus the lane bit for byte accesses. The port carries byte-address bits [15:1].
- R9: Cancel high at an edge where a transfer is active aborts it, even if ready is also high. The port is zero in the next cycle, no counter changes, and the shadow is not updated.
- R10: While reset is high, all port outputs and all four counters are zero. Releasing reset restarts the random word at SEED.
- R11: The read and write counters each increment by one for every completed (not cancelled) transfer of their direction, whatever the response flag.
- R12: After every reset, shadow word i of window w is {i ^ 5A, ~i} ^ (w ? 3C00 : 00C3), with i taken as 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, active high, asynchronous |
| gap_off | input | 1 | Disables the random extra idle cycle |
| cancel | input | 1 | Aborts the active transfer |
| req_en | output | 1 | Transfer request |
| req_addr | output | 15 | Byte-address bits [15:1] |
| req_strb | output | 2 | Write byte strobe, 00 for read |
| req_wdata | output | 16 | Write data |
| rsp_rdata | input | 16 | Read data, sampled with ready |
| rsp_ready | input | 1 | Transfer complete |
| rsp_err | input | 1 | Response flag, 1 = failed |
| n_reads | output | CNT_W | Completed reads |
| n_writes | output | CNT_W | Completed writes |
| n_rd_err | output | CNT_W | Failed or mismatching reads |
| n_wr_err | output | CNT_W | Failed writes |

## Verification
A new request appears on the port half a cycle after its launch edge. The launch edge comes one cycle after the previous release, or two cycles after it when the random gap is taken. The bench therefore counts the falling edges with enable low before comparing the request fields. Counters, the released port and any shadow update all change on the completing edge itself. Every effect of a completion or a cancel is sampled at the falling edge that follows that edge, and each cycle of a held request is compared at its own falling edge. The bench model also runs through reset, so it can check that the preload and the random sequence both restart.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_BUSY = 2'd2
  } mst_state_e;

  // Field positions inside the 32-bit random word
  localparam int F_GAP_LO  = 0;
  localparam int F_DIR_LO  = 8;
  localparam int F_WIN     = 16;
  localparam int F_OFF_LO  = 17;
  localparam int F_WIDE    = 24;
  localparam int F_LANE    = 25;
  localparam logic [7:0] THIRD_LIMIT = 8'd85;

  function automatic logic [31:0] rng_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic one_in_three(input logic [7:0] v);
    return v < THIRD_LIMIT;
  endfunction

  function automatic logic [1:0] lane_strobe(input logic wr, input logic wide,
                                             input logic lane);
    if (!wr)  return 2'b00;
    if (wide) return 2'b11;
    return lane ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [15:0] lane_mask(input logic wide, input logic lane);
    if (wide) return 16'hFFFF;
    return lane ? 16'hFF00 : 16'h00FF;
  endfunction

  function automatic logic [15:0] lane_place(input logic wide, input logic lane,
                                             input logic [15:0] d);
    if (wide) return d;
    return lane ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
  endfunction

  function automatic logic [15:0] merge_bytes(input logic [15:0] old_w,
                                              input logic [15:0] new_w,
                                              input logic [1:0]  strb);
    return {strb[1] ? new_w[15:8] : old_w[15:8],
            strb[0] ? new_w[7:0]  : old_w[7:0]};
  endfunction

  function automatic logic [15:0] preload_word(input logic win, input logic [7:0] idx);
    return {idx ^ 8'h5A, ~idx} ^ (win ? 16'h3C00 : 16'h00C3);
  endfunction

  function automatic logic [15:0] win_byte_addr(input logic [15:0] base,
                                                input logic [15:0] off,
                                                input logic lane);
    return base + (off << 1) + {15'd0, lane};
  endfunction

endpackage

// File: rtl/mst_rng.sv
module mst_rng
  import mst_pkg::*;
#(
  parameter logic [31:0] SEED = 32'hACE1_2468
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [31:0] word
);
  localparam logic [31:0] SAFE_SEED = (SEED == 32'd0) ? 32'd1 : SEED;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       word <= SAFE_SEED;
    else if (step) word <= rng_step(word);
  end
endmodule

// File: rtl/mst_shadow.sv
module mst_shadow
  import mst_pkg::*;
#(
  parameter int WIN_AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              sel_win,
  input  logic [WIN_AW-1:0] sel_idx,
  input  logic [1:0]        upd_strb,
  input  logic [15:0]       upd_data,
  output logic [15:0]       rd_word
);
  localparam int WIN_WORDS = 1 << WIN_AW;

  logic [1:0][15:0] win_word;

  for (genvar w = 0; w < 2; w++) begin : g_win
    logic [15:0] words [WIN_WORDS];

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        for (int i = 0; i < WIN_WORDS; i++)
          words[i] <= preload_word(1'(w), 8'(i));
      end else if (upd && (sel_win == 1'(w))) begin
        words[sel_idx] <= merge_bytes(words[sel_idx], upd_data, upd_strb);
      end
    end

    assign win_word[w] = words[sel_idx];
  end

  assign rd_word = win_word[sel_win];
endmodule

// File: rtl/mst_tally.sv
module mst_tally #(
  parameter int CNT_W = 16,
  parameter int NUM   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM-1:0]            bump,
  output logic [NUM-1:0][CNT_W-1:0] count
);
  for (genvar k = 0; k < NUM; k++) begin : g_cnt
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk or posedge rst) begin
      if (rst)          c <= '0;
      else if (bump[k]) c <= c + 1'b1;
    end
    assign count[k] = c;
  end
endmodule

// File: rtl/mem_stress_master.sv
module mem_stress_master
  import mst_pkg::*;
#(
  parameter logic [31:0] SEED      = 32'hACE1_2468,
  parameter logic [15:0] PWIN_BASE = 16'hFE00,
  parameter logic [15:0] DWIN_BASE = 16'h0400,
  parameter int          WIN_AW    = 7,
  parameter bit          BYTE_MIX  = 1'b1,
  parameter int          CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gap_off,
  input  logic             cancel,
  output logic             req_en,
  output logic [14:0]      req_addr,
  output logic [1:0]       req_strb,
  output logic [15:0]      req_wdata,
  input  logic [15:0]      rsp_rdata,
  input  logic             rsp_ready,
  input  logic             rsp_err,
  output logic [CNT_W-1:0] n_reads,
  output logic [CNT_W-1:0] n_writes,
  output logic [CNT_W-1:0] n_rd_err,
  output logic [CNT_W-1:0] n_wr_err
);
  localparam int NUM_CNT = 4;

  mst_state_e        state;
  logic [31:0]       rnd;
  logic              cur_rd, cur_win, cur_wide, cur_lane;
  logic [WIN_AW-1:0] cur_off;
  logic [15:0]       shadow_word;

  // Decisions taken from the current random word
  logic              pick_gap, pick_rd, pick_win, pick_wide, pick_lane;
  logic [WIN_AW-1:0] pick_off;
  logic [15:0]       pick_data, pick_baddr;

  assign pick_gap   = one_in_three(rnd[F_GAP_LO +: 8]) && !gap_off;
  assign pick_rd    = one_in_three(rnd[F_DIR_LO +: 8]);
  assign pick_win   = rnd[F_WIN];
  assign pick_off   = rnd[F_OFF_LO +: WIN_AW];
  assign pick_wide  = BYTE_MIX ? rnd[F_WIDE] : 1'b1;
  assign pick_lane  = pick_wide ? 1'b0 : rnd[F_LANE];
  assign pick_data  = rnd[31:16] ^ {rnd[7:0], rnd[15:8]};
  assign pick_baddr = win_byte_addr(pick_win ? PWIN_BASE : DWIN_BASE,
                                    16'(pick_off), pick_lane);

  // Named events for the sequencer and the checker
  logic launch_ev, gap_ev, done_ev, abort_ev, rd_bad;

  assign launch_ev = (state == ST_GAP) || ((state == ST_IDLE) && !pick_gap);
  assign gap_ev    = (state == ST_IDLE) && pick_gap;
  assign done_ev   = (state == ST_BUSY) && rsp_ready && !cancel;
  assign abort_ev  = (state == ST_BUSY) && cancel;
  assign rd_bad    = ((rsp_rdata ^ shadow_word) & lane_mask(cur_wide, cur_lane)) != 16'h0;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_en    <= 1'b0;
      req_addr  <= '0;
      req_strb  <= '0;
      req_wdata <= '0;
      cur_rd    <= 1'b0;
      cur_win   <= 1'b0;
      cur_off   <= '0;
      cur_wide  <= 1'b0;
      cur_lane  <= 1'b0;
    end else if (launch_ev) begin
      state     <= ST_BUSY;
      req_en    <= 1'b1;
      req_addr  <= pick_baddr[15:1];
      req_strb  <= lane_strobe(!pick_rd, pick_wide, pick_lane);
      req_wdata <= pick_rd ? 16'h0 : lane_place(pick_wide, pick_lane, pick_data);
      cur_rd    <= pick_rd;
      cur_win   <= pick_win;
      cur_off   <= pick_off;
      cur_wide  <= pick_wide;
      cur_lane  <= pick_lane;
    end else if (gap_ev) begin
      state <= ST_GAP;
    end else if (done_ev || abort_ev) begin
      state     <= ST_IDLE;
      req_en    <= 1'b0;
      req_addr  <= '0;
      req_strb  <= '0;
      req_wdata <= '0;
    end
  end

  mst_rng #(.SEED(SEED)) u_rng (
    .clk  (clk),
    .rst  (rst),
    .step (launch_ev),
    .word (rnd)
  );

  mst_shadow #(.WIN_AW(WIN_AW)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .upd      (done_ev && !cur_rd && !rsp_err),
    .sel_win  (cur_win),
    .sel_idx  (cur_off),
    .upd_strb (req_strb),
    .upd_data (req_wdata),
    .rd_word  (shadow_word)
  );

  logic [NUM_CNT-1:0]            bump;
  logic [NUM_CNT-1:0][CNT_W-1:0] count;

  assign bump[0] = done_ev && cur_rd;
  assign bump[1] = done_ev && !cur_rd;
  assign bump[2] = done_ev && cur_rd && (rsp_err || rd_bad);
  assign bump[3] = done_ev && !cur_rd && rsp_err;

  mst_tally #(.CNT_W(CNT_W), .NUM(NUM_CNT)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .bump  (bump),
    .count (count)
  );

  assign n_reads  = count[0];
  assign n_writes = count[1];
  assign n_rd_err = count[2];
  assign n_wr_err = count[3];
endmodule

// File: rtl/mem_stress_master_chk.sv
module mem_stress_master_chk #(
  parameter logic [15:0] PWIN_BASE = 16'hFE00,
  parameter logic [15:0] DWIN_BASE = 16'h0400,
  parameter int          WIN_AW    = 7,
  parameter int          CNT_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             gap_off,
  input logic             cancel,
  input logic             req_en,
  input logic [14:0]      req_addr,
  input logic [1:0]       req_strb,
  input logic [15:0]      req_wdata,
  input logic             rsp_ready,
  input logic             rsp_err,
  input logic [CNT_W-1:0] n_reads,
  input logic [CNT_W-1:0] n_writes,
  input logic [CNT_W-1:0] n_rd_err,
  input logic [CNT_W-1:0] n_wr_err,
  input logic             launch_ev,
  input logic             done_ev,
  input logic             abort_ev
);
  localparam logic [16:0] SPAN = 17'(2 << WIN_AW);

  logic [16:0] a17;
  logic        in_win;

  assign a17    = {1'b0, req_addr, 1'b0};
  assign in_win = ((a17 >= {1'b0, PWIN_BASE}) && (a17 < {1'b0, PWIN_BASE} + SPAN)) ||
                  ((a17 >= {1'b0, DWIN_BASE}) && (a17 < {1'b0, DWIN_BASE} + SPAN));

  // R1: a byte write leaves the unused lane at zero
  p_lane_r1: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_strb == 2'b01) |-> (req_wdata[15:8] == 8'h00));
  p_lane_hi_r1: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_strb == 2'b10) |-> (req_wdata[7:0] == 8'h00));

  // R2: request held until ready
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (req_en && !rsp_ready && !cancel) |=>
      (req_en && $stable(req_addr) && $stable(req_strb) && $stable(req_wdata)));

  // R3: port zero after completion or abort
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (done_ev || abort_ev) |=>
      (!req_en && req_addr == 15'd0 && req_strb == 2'b00 && req_wdata == 16'h0));

  // R4: a failed write bumps the write-error counter
  p_wr_err_r4: assert property (@(posedge clk) disable iff (rst)
    (done_ev && req_strb != 2'b00 && rsp_err) |=>
      (n_wr_err == CNT_W'($past(n_wr_err) + 1'b1)));

  // R6: with the gap disabled, launch follows the single idle cycle
  p_gapoff_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(done_ev) && gap_off) |=> req_en);
  p_launch_r6: assert property (@(posedge clk) disable iff (rst)
    launch_ev |=> req_en);

  // R8: every request addresses one of the two windows
  p_window_r8: assert property (@(posedge clk) disable iff (rst)
    req_en |-> in_win);

  // R9: cancel leaves all counters unchanged
  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    abort_ev |=> ($stable(n_reads) && $stable(n_writes) &&
                  $stable(n_rd_err) && $stable(n_wr_err)));

  // R11: a completed read bumps the read counter by one
  p_count_r11: assert property (@(posedge clk) disable iff (rst)
    (done_ev && req_strb == 2'b00) |=> (n_reads == CNT_W'($past(n_reads) + 1'b1)));
endmodule

bind mem_stress_master mem_stress_master_chk #(
  .PWIN_BASE (PWIN_BASE),
  .DWIN_BASE (DWIN_BASE),
  .WIN_AW    (WIN_AW),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gap_off   (gap_off),
  .cancel    (cancel),
  .req_en    (req_en),
  .req_addr  (req_addr),
  .req_strb  (req_strb),
  .req_wdata (req_wdata),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .n_reads   (n_reads),
  .n_writes  (n_writes),
  .n_rd_err  (n_rd_err),
  .n_wr_err  (n_wr_err),
  .launch_ev (launch_ev),
  .done_ev   (done_ev),
  .abort_ev  (abort_ev)
);

// File: tb/mem_stress_master_tb.sv
module mem_stress_master_tb;
  localparam logic [31:0] SEED  = 32'h1D87_2C4B;
  localparam logic [15:0] PBASE = 16'hFE00;
  localparam logic [15:0] DBASE = 16'h0400;
  localparam int          CW    = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, gap_off, cancel;
  logic          req_en;
  logic [14:0]   req_addr;
  logic [1:0]    req_strb;
  logic [15:0]   req_wdata;
  logic [15:0]   rsp_rdata;
  logic          rsp_ready, rsp_err;
  logic [CW-1:0] n_reads, n_writes, n_rd_err, n_wr_err;

  mem_stress_master #(
    .SEED(SEED), .PWIN_BASE(PBASE), .DWIN_BASE(DBASE),
    .WIN_AW(7), .BYTE_MIX(1'b1), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst(rst), .gap_off(gap_off), .cancel(cancel),
    .req_en(req_en), .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .n_reads(n_reads), .n_writes(n_writes), .n_rd_err(n_rd_err), .n_wr_err(n_wr_err)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [15:0] bmem [2][128];
  logic [31:0] m_rng;
  int          e_rd, e_wr, e_rerr, e_werr;

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s : actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  // R12 pattern, restated arithmetically
  function automatic logic [15:0] init_word(input int w, input int i);
    int v;
    v = ((i ^ 'h5A) % 256) * 256 + (255 - i);
    v = v ^ ((w == 1) ? 'h3C00 : 'h00C3);
    return 16'(v);
  endfunction

  task automatic model_reset();
    m_rng = SEED;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 128; i++) bmem[w][i] = init_word(w, i);
    e_rd = 0; e_wr = 0; e_rerr = 0; e_werr = 0;
  endtask

  task automatic check_counts(input string tag);
    check({tag, " reads"},      64'(n_reads),  64'(e_rd));
    check({tag, " writes"},     64'(n_writes), 64'(e_wr));
    check({tag, " read errs"},  64'(n_rd_err), 64'(e_rerr));
    check({tag, " write errs"}, 64'(n_wr_err), 64'(e_werr));
  endtask

  // corrupt: 0 none, 1 flip a bit inside the mask, 2 flip a bit outside it
  task automatic xfer(input int lat, input bit err, input int corrupt, input bit abort);
    logic [31:0] s;
    logic        g, rd, win, wide, lane;
    logic [6:0]  off;
    logic [15:0] d, baddr, ew, flip;
    logic [1:0]  es;
    int          idle, w;
    s    = m_rng;
    g    = (s[7:0] < 8'd85) && !gap_off;
    rd   = (s[15:8] < 8'd85);
    win  = s[16];
    off  = s[23:17];
    wide = s[24];
    lane = wide ? 1'b0 : s[25];
    d    = s[31:16] ^ {s[7:0], s[15:8]};
    m_rng = {s[30:0], ^(s & 32'h8020_0003)};
    baddr = (win ? PBASE : DBASE) + 16'(off) * 16'd2 + (wide ? 16'd0 : 16'(lane));
    es = rd ? 2'b00 : (wide ? 2'b11 : (lane ? 2'b10 : 2'b01));
    ew = rd ? 16'h0 : (wide ? d : (lane ? {d[7:0], 8'h00} : {8'h00, d[7:0]}));
    w  = win ? 1 : 0;

    idle = 1;
    @(negedge clk);
    while (!req_en && idle < 20) begin
      idle++;
      @(negedge clk);
    end
    check("R6 idle cycles before launch", 64'(idle), g ? 64'd2 : 64'd1);
    check("R7 read or write choice", 64'(req_strb == 2'b00), 64'(rd));
    check("R8 word address", 64'(req_addr), 64'(baddr[15:1]));
    check("R1 strobe", 64'(req_strb), 64'(es));
    check("R1 write data lane", 64'(req_wdata), 64'(ew));

    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      check("R2 request held", 64'({req_en, req_strb, req_addr, req_wdata}),
            64'({1'b1, es, baddr[15:1], ew}));
    end

    if (corrupt == 1) flip = wide ? 16'h8000 : (lane ? 16'h0100 : 16'h0001);
    else if (corrupt == 2) flip = wide ? 16'h0000 : (lane ? 16'h0001 : 16'h0100);
    else flip = 16'h0000;

    if (abort) begin
      cancel    = 1'b1;
      rsp_ready = err;
      @(negedge clk);
      cancel    = 1'b0;
      rsp_ready = 1'b0;
      check("R9 port released on cancel",
            64'({req_en, req_strb, req_addr, req_wdata}), 64'd0);
      check_counts("R9 counters after cancel");
      return;
    end

    rsp_ready = 1'b1;
    rsp_err   = err;
    rsp_rdata = rd ? (bmem[w][off] ^ flip) : 16'hFFFF;
    @(negedge clk);
    rsp_ready = 1'b0;
    rsp_err   = 1'b0;
    rsp_rdata = 16'h0;
    if (rd) begin
      e_rd++;
      if (err || corrupt == 1) e_rerr++;
    end else begin
      e_wr++;
      if (err) e_werr++;
      else begin
        if (es[0]) bmem[w][off][7:0]  = ew[7:0];
        if (es[1]) bmem[w][off][15:8] = ew[15:8];
      end
    end
    check("R3 port zero after completion",
          64'({req_en, req_strb, req_addr, req_wdata}), 64'd0);
    check("R11 read count", 64'(n_reads), 64'(e_rd));
    check("R11 write count", 64'(n_writes), 64'(e_wr));
    check("R4 write error count", 64'(n_wr_err), 64'(e_werr));
    check("R5 read error count", 64'(n_rd_err), 64'(e_rerr));
  endtask

  task automatic reset_check();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 port zero in reset", 64'({req_en, req_strb, req_addr, req_wdata}), 64'd0);
    model_reset();
    check_counts("R10 counters in reset");
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; gap_off = 1'b0; cancel = 1'b0;
    rsp_ready = 1'b0; rsp_err = 1'b0; rsp_rdata = 16'h0;
    model_reset();
    reset_check();

    for (int i = 0; i < 400; i++)
      xfer(i % 4, (i % 7) == 3, (i % 5 == 1) ? 1 : ((i % 5 == 2) ? 2 : 0), (i % 23) == 11);

    gap_off = 1'b1;
    for (int i = 0; i < 150; i++)
      xfer(i % 3, (i % 9) == 4, (i % 6 == 5) ? 2 : 0, (i % 31) == 7);

    gap_off = 1'b0;
    reset_check();
    for (int i = 0; i < 150; i++)
      xfer(i % 2, 1'b0, 0, 1'b0);
    check("R12 preload after reset gives clean reads", 64'(n_rd_err), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule